// File: doc/BRIEF.md
# CPU Read Wait-State Generator

This block sits between the control strobes of an 8-bit CPU and a memory cache or controller whose read latency varies from access to access. The CPU strobes arrive asynchronously. They pass through a multi-flop synchroniser into the command clock domain. A falling read strobe, qualified by the memory-request strobe, starts a read. The block then issues a single request pulse to the memory side and starts a grace counter.

The grace period is set separately for opcode fetches and for plain memory reads, from 0 to 7 command-clock cycles. If the memory answers with read-ready inside that window, the CPU's WAIT line is never pulled, so a cache hit costs no wait states. If the window runs out first, WAIT is pulled low and held until the data arrives. The data is then latched for the CPU, and WAIT is released on the following cycle. Releasing the read strobe always frees WAIT and re-arms the counter for the next bus cycle. Writes and I/O cycles are not handled.

Top module: `rdwait_gen`

## Requirements
- R1: During and right after reset, `cpu_wait_n` is high, `mem_rd_req` is low and `cpu_rd_data` is zero.
- R2: A read starts when the synchronised `cpu_rd_n` falls while the synchronised `cpu_mreq_n` is low. `mem_rd_req` is then high for exactly one cycle, starting after the third clock edge following the strobe change. Exactly one pulse is issued per bus cycle, however long the read strobe is held.
- R3: `mem_rd_fetch` is 1 in the request cycle when `cpu_m1_n` was low at the start of the read (opcode fetch). It is 0 when `cpu_m1_n` was high (memory read).
- R4: For an opcode fetch, number the request cycle as cycle 0. If `mem_rd_ready` is not high in any of cycles 0 to FETCH_DELAY, `cpu_wait_n` goes low in cycle FETCH_DELAY+1.
- R5: For a memory read, the same rule applies with MEMRD_DELAY in place of FETCH_DELAY.
- R6: If `mem_rd_ready` is high in a cycle no later than the configured delay, `cpu_wait_n` stays high for the whole bus cycle. This includes delay 0 with ready in the request cycle.
- R7: When `mem_rd_ready` is high during an active read that has not yet completed, `mem_rd_data` is latched onto `cpu_rd_data` and `cpu_wait_n` is high in the following cycle.
- R8: Once the synchronised read strobe is high, `cpu_wait_n` is high from the next cycle on. This holds even if no data arrived. The counter is cleared, so the next read gets its full grace period.
- R9: A read strobe with `cpu_mreq_n` high (an I/O read) issues no request and never pulls WAIT.
- R10: `mem_rd_ready` while no read is active, or after the current read has already latched its data, leaves `cpu_rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cpu_m1_n | input | 1 | CPU opcode-fetch strobe, active low, asynchronous |
| cpu_mreq_n | input | 1 | CPU memory-request strobe, active low, asynchronous |
| cpu_rd_n | input | 1 | CPU read strobe, active low, asynchronous |
| mem_rd_ready | input | 1 | Memory side: read data valid this cycle |
| mem_rd_data | input | DATA_W | Memory side: returned read data |
| mem_rd_req | output | 1 | One-cycle read request to the memory side |
| mem_rd_fetch | output | 1 | Qualifies `mem_rd_req`: 1 for opcode fetch |
| cpu_wait_n | output | 1 | WAIT to the CPU, active low |
| cpu_rd_data | output | DATA_W | Latched read data for the CPU bus |

## Verification
The request pulse is due three clock edges after the strobes change: two synchroniser stages and one edge-detect register. The monitor therefore numbers every later cycle from the sample in which it sees that pulse. With ready arriving in cycle j, the first wait cycle is delay+1 and the last is cycle j, so j−delay cycles of WAIT are expected, and the data is due in cycle j+1. After an abandoned read, WAIT must be high again in cycle a+3, where a is the cycle in which the read strobe rose. The driver computes these numbers from the requirements and queues them. The monitor samples one nanosecond after each rising edge and compares the counted pulse, tag, first-wait cycle, wait count and data when the driver closes the bus cycle.

// File: rtl/rdwait_pkg.sv
package rdwait_pkg;

   typedef enum logic {
      KIND_MEMRD = 1'b0,
      KIND_FETCH = 1'b1
   } rd_kind_e;

   typedef struct packed {
      logic m1_n;
      logic mreq_n;
      logic rd_n;
   } cpu_strobes_t;

   localparam int unsigned STROBE_W  = $bits(cpu_strobes_t);
   localparam int unsigned DELAY_MAX = 7;

endpackage

// File: rtl/rdwait_sync.sv
module rdwait_sync #(
   parameter int unsigned W       = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   initial begin
      assert (STAGES >= 2) else $fatal(1, "rdwait_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_q[g-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/rdwait_detect.sv
module rdwait_detect
   import rdwait_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  cpu_strobes_t strb_s,
   output logic         start,
   output rd_kind_e     start_kind,
   output logic         rd_idle
);

   logic rd_prev_n;

   always_ff @(posedge clk) begin
      if (!rst_n) rd_prev_n <= 1'b1;
      else        rd_prev_n <= strb_s.rd_n;
   end

   // memory read begins on the falling read strobe with memory request low
   assign start      = rd_prev_n & ~strb_s.rd_n & ~strb_s.mreq_n;
   assign start_kind = strb_s.m1_n ? KIND_MEMRD : KIND_FETCH;
   assign rd_idle    = strb_s.rd_n;

endmodule

// File: rtl/rdwait_timer.sv
module rdwait_timer
   import rdwait_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned FETCH_DELAY = 3,
   parameter int unsigned MEMRD_DELAY = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  rd_kind_e          start_kind,
   input  logic              rd_idle,
   input  logic              mem_rd_ready,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              mem_rd_req,
   output logic              mem_rd_fetch,
   output logic              cpu_wait_n,
   output logic [DATA_W-1:0] cpu_rd_data
);

   localparam int unsigned MAX_D = (FETCH_DELAY > MEMRD_DELAY) ? FETCH_DELAY : MEMRD_DELAY;
   localparam int unsigned CNT_W = (MAX_D < 1) ? 1 : $clog2(MAX_D + 1);

   logic              active_q;
   logic              done_q;
   logic              req_q;
   logic              wait_n_q;
   rd_kind_e          kind_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  limit;
   logic [DATA_W-1:0] data_q;

   if (FETCH_DELAY == MEMRD_DELAY) begin : g_same_limit
      assign limit = CNT_W'(FETCH_DELAY);
   end else begin : g_split_limit
      assign limit = (kind_q == KIND_FETCH) ? CNT_W'(FETCH_DELAY) : CNT_W'(MEMRD_DELAY);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         done_q   <= 1'b0;
         req_q    <= 1'b0;
         wait_n_q <= 1'b1;
         kind_q   <= KIND_MEMRD;
         cnt_q    <= '0;
         data_q   <= '0;
      end else begin
         req_q <= 1'b0;
         if (rd_idle) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            wait_n_q <= 1'b1;
            cnt_q    <= '0;
         end else if (start) begin
            active_q <= 1'b1;
            done_q   <= 1'b0;
            req_q    <= 1'b1;
            wait_n_q <= 1'b1;
            kind_q   <= start_kind;
            cnt_q    <= '0;
         end else if (active_q && !done_q) begin
            if (mem_rd_ready) begin
               data_q   <= mem_rd_data;
               done_q   <= 1'b1;
               wait_n_q <= 1'b1;
            end else if (cnt_q >= limit) begin
               wait_n_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign mem_rd_req   = req_q;
   assign mem_rd_fetch = (kind_q == KIND_FETCH);
   assign cpu_wait_n   = wait_n_q;
   assign cpu_rd_data  = data_q;

   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |=> !req_q); // R2

   AST_READY_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !done_q && !rd_idle && mem_rd_ready) |=> (wait_n_q && done_q)); // R7

   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!active_q || done_q) |-> $stable(data_q)); // R10

endmodule

// File: rtl/rdwait_gen.sv
module rdwait_gen
   import rdwait_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FETCH_DELAY = 3,
   parameter int unsigned MEMRD_DELAY = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_m1_n,
   input  logic              cpu_mreq_n,
   input  logic              cpu_rd_n,
   input  logic              mem_rd_ready,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              mem_rd_req,
   output logic              mem_rd_fetch,
   output logic              cpu_wait_n,
   output logic [DATA_W-1:0] cpu_rd_data
);

   initial begin
      assert (FETCH_DELAY <= DELAY_MAX) else $fatal(1, "rdwait_gen: FETCH_DELAY above 7");
      assert (MEMRD_DELAY <= DELAY_MAX) else $fatal(1, "rdwait_gen: MEMRD_DELAY above 7");
      assert (DATA_W >= 1) else $fatal(1, "rdwait_gen: DATA_W must be positive");
   end

   cpu_strobes_t strb_raw;
   cpu_strobes_t strb_s;
   logic         start;
   rd_kind_e     start_kind;
   logic         rd_idle;

   assign strb_raw = '{m1_n: cpu_m1_n, mreq_n: cpu_mreq_n, rd_n: cpu_rd_n};

   rdwait_sync #(
      .W       (STROBE_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({STROBE_W{1'b1}})
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (strb_raw),
      .dout  (strb_s)
   );

   rdwait_detect u_detect (
      .clk        (clk),
      .rst_n      (rst_n),
      .strb_s     (strb_s),
      .start      (start),
      .start_kind (start_kind),
      .rd_idle    (rd_idle)
   );

   rdwait_timer #(
      .DATA_W      (DATA_W),
      .FETCH_DELAY (FETCH_DELAY),
      .MEMRD_DELAY (MEMRD_DELAY)
   ) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .start_kind   (start_kind),
      .rd_idle      (rd_idle),
      .mem_rd_ready (mem_rd_ready),
      .mem_rd_data  (mem_rd_data),
      .mem_rd_req   (mem_rd_req),
      .mem_rd_fetch (mem_rd_fetch),
      .cpu_wait_n   (cpu_wait_n),
      .cpu_rd_data  (cpu_rd_data)
   );

   AST_IDLE_FREES_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_idle |=> cpu_wait_n); // R8

   AST_REQ_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !rd_idle); // R2

endmodule

// File: tb/rdwait_gen_bench.sv
`timescale 1ns/100ps
module rdwait_gen_bench;

   localparam int FD = 2;
   localparam int MD = 4;

   typedef struct {
      string tag;
      bit    fetch;
      int    exp_req;
      int    exp_first;
      int    exp_waits;
      int    exp_data;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_m1_n = 1'b1;
   logic       cpu_mreq_n = 1'b1;
   logic       cpu_rd_n = 1'b1;
   logic       mem_rd_ready = 1'b0;
   logic [7:0] mem_rd_data = 8'h00;
   logic       mem_rd_req;
   logic       mem_rd_fetch;
   logic       cpu_wait_n;
   logic [7:0] cpu_rd_data;

   logic       txn_end = 1'b0;
   bit         finished = 1'b0;
   int         checks = 0;
   int         errors = 0;
   int         last_data = 0;
   exp_t       exp_q[$];

   int  req_cnt = 0;
   int  cyc = 0;
   bit  have_req = 1'b0;
   bit  fetch_seen = 1'b0;
   int  first_wait = -1;
   int  wait_cnt = 0;

   always #2 clk = ~clk;

   rdwait_gen #(
      .DATA_W      (8),
      .SYNC_STAGES (2),
      .FETCH_DELAY (FD),
      .MEMRD_DELAY (MD)
   ) u_rdwait_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_m1_n     (cpu_m1_n),
      .cpu_mreq_n   (cpu_mreq_n),
      .cpu_rd_n     (cpu_rd_n),
      .mem_rd_ready (mem_rd_ready),
      .mem_rd_data  (mem_rd_data),
      .mem_rd_req   (mem_rd_req),
      .mem_rd_fetch (mem_rd_fetch),
      .cpu_wait_n   (cpu_wait_n),
      .cpu_rd_data  (cpu_rd_data)
   );

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   // driver: lat >= 0 -> ready in cycle lat after request; lat < 0 -> abandon after abort cycles
   task automatic do_read(input string tag, input bit fetch, input bit io, input int lat,
                          input int abort, input logic [7:0] d);
      exp_t e;
      int   dl;
      dl = fetch ? FD : MD;
      e.tag = tag;
      e.fetch = fetch;
      if (io) begin
         e.exp_req = 0; e.exp_first = -1; e.exp_waits = 0; e.exp_data = last_data;
      end else if (lat >= 0) begin
         e.exp_req = 1;
         e.exp_waits = (lat > dl) ? lat - dl : 0;
         e.exp_first = (lat > dl) ? dl + 1 : -1;
         e.exp_data = d;
         last_data = d;
      end else begin
         e.exp_req = 1;
         e.exp_waits = (abort + 2 > dl) ? abort + 2 - dl : 0;
         e.exp_first = (abort + 2 > dl) ? dl + 1 : -1;
         e.exp_data = last_data;
      end
      exp_q.push_back(e);

      @(negedge clk);
      cpu_m1_n = !fetch;
      cpu_mreq_n = io;
      cpu_rd_n = 1'b0;
      repeat (3) @(negedge clk);
      if (io) begin
         repeat (2) @(negedge clk);
         mem_rd_ready = 1'b1; mem_rd_data = d;   // stray ready, R10
         @(negedge clk);
         mem_rd_ready = 1'b0;
         repeat (8) @(negedge clk);
      end else if (lat >= 0) begin
         repeat (lat) @(negedge clk);
         mem_rd_ready = 1'b1; mem_rd_data = d;
         @(negedge clk);
         mem_rd_ready = 1'b0;
         @(negedge clk);
         mem_rd_ready = 1'b1; mem_rd_data = ~d;  // late second ready, R10
         @(negedge clk);
         mem_rd_ready = 1'b0;
         repeat (2) @(negedge clk);
      end else begin
         repeat (abort) @(negedge clk);
      end
      cpu_rd_n = 1'b1;
      cpu_mreq_n = 1'b1;
      cpu_m1_n = 1'b1;
      repeat (4) @(negedge clk);
      txn_end = 1'b1;
      @(negedge clk);
      txn_end = 1'b0;
      @(negedge clk);
   endtask

   // monitor: samples 1 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n) begin
            if (mem_rd_req) begin
               req_cnt++;
               fetch_seen = mem_rd_fetch;
               cyc = 0;
               have_req = 1'b1;
            end else if (have_req) begin
               cyc++;
            end
            if (!cpu_wait_n) begin
               wait_cnt++;
               if (first_wait < 0) first_wait = have_req ? cyc : -2;
            end
            if (txn_end) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R2", "unexpected close", 0, 1);
               end else begin
                  exp_t e;
                  string rw;
                  e = exp_q.pop_front();
                  rw = e.fetch ? "R4" : "R5";
                  chk(req_cnt == e.exp_req, (e.exp_req == 0) ? "R9" : "R2",
                      {e.tag, " request count"}, req_cnt, e.exp_req);
                  if (e.exp_req == 1)
                     chk(fetch_seen == e.fetch, "R3", {e.tag, " fetch tag"}, fetch_seen, e.fetch);
                  chk(first_wait == e.exp_first, (e.exp_first < 0) ? "R6" : rw,
                      {e.tag, " first wait cycle"}, first_wait, e.exp_first);
                  chk(wait_cnt == e.exp_waits, (e.exp_waits == 0) ? "R6" : rw,
                      {e.tag, " wait cycles"}, wait_cnt, e.exp_waits);
                  chk(int'(cpu_rd_data) == e.exp_data, "R7", {e.tag, " data (R10 hold)"},
                      cpu_rd_data, e.exp_data);
                  chk(cpu_wait_n == 1'b1, "R8", {e.tag, " wait freed"}, cpu_wait_n, 1);
               end
               req_cnt = 0; cyc = 0; have_req = 1'b0; first_wait = -1; wait_cnt = 0;
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(cpu_wait_n == 1'b1, "R1", "wait in reset", cpu_wait_n, 1);
      chk(mem_rd_req == 1'b0, "R1", "req in reset", mem_rd_req, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(cpu_rd_data == 8'h00, "R1", "data after reset", cpu_rd_data, 0);
      chk(cpu_wait_n == 1'b1, "R1", "wait after reset", cpu_wait_n, 1);

      // stray ready while idle must not load data (R10)
      mem_rd_ready = 1'b1; mem_rd_data = 8'h5A;
      @(negedge clk);
      mem_rd_ready = 1'b0;
      repeat (2) @(negedge clk);
      chk(cpu_rd_data == 8'h00, "R10", "idle ready ignored", cpu_rd_data, 0);

      do_read("fetch hit lat0",   1'b1, 1'b0, 0, 0, 8'h11);   // R6
      do_read("fetch hit edge",   1'b1, 1'b0, FD, 0, 8'h22);  // R6
      do_read("fetch miss",       1'b1, 1'b0, 5, 0, 8'h33);   // R4
      do_read("mem hit edge",     1'b0, 1'b0, MD, 0, 8'h44);  // R6
      do_read("mem miss",         1'b0, 1'b0, 7, 0, 8'h55);   // R5
      do_read("mem abandoned",    1'b0, 1'b0, -1, 8, 8'h66);  // R8
      do_read("fetch after drop", 1'b1, 1'b0, FD, 0, 8'h77);  // R8 full grace
      do_read("io read",          1'b0, 1'b1, 0, 0, 8'h88);   // R9
      do_read("mem hit lat0",     1'b0, 1'b0, 0, 0, 8'h99);   // R6
      do_read("fetch long miss",  1'b1, 1'b0, 9, 0, 8'hA5);   // R4

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R2", "all bus cycles closed", exp_q.size(), 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule